// File: doc/BRIEF.md
# Shared Register File with Two-Master Arbitration

This block holds a 128-word, 16-bit register file that two independent masters can reach. The first master is a plain synchronous register port: a one-cycle enable, a write flag, a 7-bit address and write data go in, and a ready pulse comes back together with read data. The second master delivers 32-bit command words that another block has already assembled from a serial stream. Each word asks for a read, a write or nothing at all.

The lower half of the address space holds measurement results. An internal update port loads these locations, and neither master can change them. The upper half is control storage that both masters can read and write. An arbiter hands the file to one whole transaction at a time. The register port has priority when both masters arrive together. A request that loses is kept and is served as soon as the winning transaction has finished.

Top module: `dual_master_regport`

## Requirements
- R1: Addresses 0x00 to 0x3F are status words and addresses 0x40 to 0x7F are control words. All words are 16 bits wide, and every control word reads 0 after reset.
- R2: The register port samples `f_we`, `f_addr` and `f_wdata` on the rising edge at which `f_en` is high. With no contention, `f_rdy` is high during the second cycle after that edge. For a read, `f_rdata` holds the addressed word while `f_rdy` is high.
- R3: Each completed transaction, read or write, gives exactly one single-cycle ready pulse to the master that issued it.
- R4: A write from either master to a status address leaves that word unchanged. The write still completes with a ready pulse.
- R5: Only one transaction is in progress at any time, and a ready pulse goes only to the master that owns the transaction that finished.
- R6: In a command word, bits [29:26] select the operation: 1 is a read, 2 is a write, and any other value is a no-operation. Bits [22:16] carry the address and bits [25:23] are ignored. Bits [15:0] carry the write data. A no-operation produces no ready pulse and changes no register.
- R7: When both masters present a request on the same edge, the register port is served first. The command is served next, and its ready pulse comes two cycles after the register port's pulse.
- R8: When `st_we` is high, the 12-bit `st_value` is stored MSB-justified at status address `st_addr`. The value goes in bits [15:4] and bits [3:0] are written as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_en | input | 1 | Register-port request strobe, one cycle |
| f_we | input | 1 | Register-port write flag |
| f_addr | input | 7 | Register-port address |
| f_wdata | input | 16 | Register-port write data |
| f_rdata | output | 16 | Register-port read data |
| f_rdy | output | 1 | Register-port completion pulse |
| c_valid | input | 1 | Command word present, one cycle |
| c_word | input | 32 | Command word |
| c_rdata | output | 16 | Command-side read data |
| c_rdy | output | 1 | Command-side completion pulse |
| st_we | input | 1 | Status update strobe |
| st_addr | input | 6 | Status update location |
| st_value | input | 12 | Status update value |

## Verification
The bench sends requests from both masters on the same edge and measures each latency. A design that ignores the priority, or that lets two transactions overlap, returns the ready pulses in the wrong order or cycle, or returns both at once. Writes to status addresses are read back afterwards, and a design that misses the read-only half shows the written value. Command words are sent with junk in the unused address bits, with an unused operation code and with a no-operation code. Wrong field decoding then lands a write at the wrong location, or produces a ready pulse that should not happen. A status update with a recognisable pattern is read back, and this exposes a missing or wrong MSB-justification shift.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int CMD_W  = 32;
  localparam int SMP_W  = 12;
  localparam int OP_LSB = 26;
  localparam int AD_LSB = 16;

  typedef enum logic [1:0] {OP_NOP, OP_RD, OP_WR} op_e;

  function automatic op_e cmd_op(input logic [CMD_W-1:0] w);
    logic [3:0] f;
    f = w[OP_LSB +: 4];
    if (f == 4'd1) return OP_RD;
    if (f == 4'd2) return OP_WR;
    return OP_NOP;
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [CMD_W-1:0] w);
    return w[AD_LSB +: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] msb_justify(input logic [SMP_W-1:0] v);
    return {v, {(DATA_W-SMP_W){1'b0}}};
  endfunction

  function automatic logic is_status(input logic [ADDR_W-1:0] a);
    return ~a[ADDR_W-1];
  endfunction
endpackage

// File: rtl/rpa_regfile.sv
module rpa_regfile
  import rpa_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SW = SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rword,
  input  logic          st_we,
  input  logic [AW-2:0] st_addr,
  input  logic [SW-1:0] st_value
);
  localparam int DEPTH = 2 ** AW;
  localparam int HALF  = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic          ctrl_wr;

  assign ctrl_wr   = acc_en && acc_we && !is_status(acc_addr);
  assign acc_rword = mem[acc_addr];

  for (genvar i = 0; i < HALF; i++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= '0;
      else if (st_we && st_addr == i[AW-2:0]) mem[i] <= msb_justify(st_value);
    end
  end

  for (genvar i = HALF; i < DEPTH; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= '0;
      else if (ctrl_wr && acc_addr == i[AW-1:0]) mem[i] <= acc_wdata;
    end
  end

  // R4: a status location not targeted by the update port keeps its value
  assert_status_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && is_status(acc_addr) && !st_we) |=> $stable(mem[0]) || $past(acc_addr) != '0);
endmodule

// File: rtl/rpa_arbiter.sv
module rpa_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req_f,
  input  logic req_c,
  output logic grant_f,
  output logic grant_c,
  output logic busy
);
  assign grant_f = !busy && req_f;
  assign grant_c = !busy && !req_f && req_c;

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= grant_f || grant_c;
  end

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_f, grant_c}));
  assert_no_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(grant_f || grant_c));
  assert_fab_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_f && req_c && !busy) |-> grant_f);
endmodule

// File: rtl/dual_master_regport.sv
module dual_master_regport
  import rpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_en,
  input  logic              f_we,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] f_wdata,
  output logic [DATA_W-1:0] f_rdata,
  output logic              f_rdy,
  input  logic              c_valid,
  input  logic [CMD_W-1:0]  c_word,
  output logic [DATA_W-1:0] c_rdata,
  output logic              c_rdy,
  input  logic              st_we,
  input  logic [ADDR_W-2:0] st_addr,
  input  logic [SMP_W-1:0]  st_value
);
  logic              fp_v, fp_we, cp_v, cp_we;
  logic [ADDR_W-1:0] fp_addr, cp_addr;
  logic [DATA_W-1:0] fp_data, cp_data;
  logic              grant_f, grant_c, arb_busy;
  logic              ex_v, ex_src_c, ex_we;
  logic [ADDR_W-1:0] ex_addr;
  logic [DATA_W-1:0] ex_data, rword;
  op_e               c_op;

  assign c_op = cmd_op(c_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_v <= 1'b0; fp_we <= 1'b0; fp_addr <= '0; fp_data <= '0;
    end else if (grant_f) begin
      fp_v <= 1'b0;
    end else if (f_en && !fp_v) begin
      fp_v <= 1'b1; fp_we <= f_we; fp_addr <= f_addr; fp_data <= f_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_v <= 1'b0; cp_we <= 1'b0; cp_addr <= '0; cp_data <= '0;
    end else if (grant_c) begin
      cp_v <= 1'b0;
    end else if (c_valid && !cp_v && c_op != OP_NOP) begin
      cp_v    <= 1'b1;
      cp_we   <= (c_op == OP_WR);
      cp_addr <= cmd_addr(c_word);
      cp_data <= c_word[DATA_W-1:0];
    end
  end

  rpa_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req_f(fp_v), .req_c(cp_v),
    .grant_f(grant_f), .grant_c(grant_c), .busy(arb_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_v <= 1'b0; ex_src_c <= 1'b0; ex_we <= 1'b0; ex_addr <= '0; ex_data <= '0;
    end else begin
      ex_v     <= grant_f || grant_c;
      ex_src_c <= grant_c;
      ex_we    <= grant_c ? cp_we   : fp_we;
      ex_addr  <= grant_c ? cp_addr : fp_addr;
      ex_data  <= grant_c ? cp_data : fp_data;
    end
  end

  rpa_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .acc_en(ex_v), .acc_we(ex_we), .acc_addr(ex_addr),
    .acc_wdata(ex_data), .acc_rword(rword),
    .st_we(st_we), .st_addr(st_addr), .st_value(st_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_rdy <= 1'b0; c_rdy <= 1'b0; f_rdata <= '0; c_rdata <= '0;
    end else begin
      f_rdy <= ex_v && !ex_src_c;
      c_rdy <= ex_v && ex_src_c;
      if (ex_v && !ex_src_c && !ex_we) f_rdata <= rword;
      if (ex_v &&  ex_src_c && !ex_we) c_rdata <= rword;
    end
  end

  assert_rdy_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_rdy && c_rdy));
  assert_f_rdy_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    f_rdy |=> !f_rdy);
  assert_c_rdy_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_rdy |=> !c_rdy);
  assert_rdy_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_rdy |-> $past(ex_v && ex_src_c));
endmodule

// File: tb/dual_master_regport_tb.sv
module dual_master_regport_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic f_en = 0, f_we = 0, c_valid = 0, st_we = 0;
  logic [6:0] f_addr = '0;
  logic [15:0] f_wdata = '0;
  logic [31:0] c_word = '0;
  logic [5:0] st_addr = '0;
  logic [11:0] st_value = '0;
  logic [15:0] f_rdata, c_rdata;
  logic f_rdy, c_rdy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_master_regport u_dut (
    .clk(clk), .rst_n(rst_n), .f_en(f_en), .f_we(f_we), .f_addr(f_addr),
    .f_wdata(f_wdata), .f_rdata(f_rdata), .f_rdy(f_rdy), .c_valid(c_valid),
    .c_word(c_word), .c_rdata(c_rdata), .c_rdy(c_rdy), .st_we(st_we),
    .st_addr(st_addr), .st_value(st_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcmd(input int op, input logic [9:0] a, input logic [15:0] d);
    logic [31:0] w;
    w = '0;
    w[29:26] = op[3:0];
    w[25:16] = a;
    w[15:0] = d;
    return w;
  endfunction

  task automatic fab_op(input logic we, input logic [6:0] a, input logic [15:0] d,
                        output logic [15:0] q, output int lat);
    f_en = 1; f_we = we; f_addr = a; f_wdata = d;
    @(negedge clk); f_en = 0; lat = 1;
    while (!f_rdy && lat < 20) begin @(negedge clk); lat++; end
    q = f_rdata;
  endtask

  task automatic cmd_op(input logic [31:0] w, output logic [15:0] q, output int lat);
    c_valid = 1; c_word = w;
    @(negedge clk); c_valid = 0; lat = 1;
    while (!c_rdy && lat < 20) begin @(negedge clk); lat++; end
    q = c_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] q; int lat;
    chk("R3 reset f_rdy", f_rdy, 0);
    chk("R3 reset c_rdy", c_rdy, 0);
    fab_op(0, 7'h5A, 0, q, lat);
    chk("R1 control reset value", q, 16'h0000);
  endtask

  task automatic t_fabric_rw();
    logic [15:0] q; int lat;
    fab_op(1, 7'h40, 16'hBEEF, q, lat);
    chk("R2 write latency", lat, 3);
    fab_op(0, 7'h40, 0, q, lat);
    chk("R2 read latency", lat, 3);
    chk("R2 read data", q, 16'hBEEF);
    fab_op(1, 7'h7F, 16'h1234, q, lat);
    fab_op(0, 7'h7F, 0, q, lat);
    chk("R1 top control word", q, 16'h1234);
    @(negedge clk);
    chk("R3 ready is single pulse", f_rdy, 0);
  endtask

  task automatic t_status();
    logic [15:0] q; int lat;
    @(negedge clk); st_we = 1; st_addr = 6'h03; st_value = 12'hABC;
    @(negedge clk); st_we = 0;
    fab_op(0, 7'h03, 0, q, lat);
    chk("R8 msb-justified status", q, 16'hABC0);
    fab_op(1, 7'h03, 16'h5555, q, lat);
    chk("R4 status write still ready", lat, 3);
    fab_op(0, 7'h03, 0, q, lat);
    chk("R4 status kept after fabric write", q, 16'hABC0);
    cmd_op(mkcmd(2, 10'h003, 16'h7777), q, lat);
    fab_op(0, 7'h03, 0, q, lat);
    chk("R4 status kept after command write", q, 16'hABC0);
  endtask

  task automatic t_command();
    logic [15:0] q; int lat;
    cmd_op(mkcmd(2, 10'h380 | 10'h45, 16'hC0DE), q, lat);
    chk("R6 command write latency", lat, 3);
    fab_op(0, 7'h45, 0, q, lat);
    chk("R6 high address bits ignored", q, 16'hC0DE);
    cmd_op(mkcmd(1, 10'h045, 0), q, lat);
    chk("R6 command read data", q, 16'hC0DE);
    c_valid = 1; c_word = mkcmd(0, 10'h045, 16'h0001);
    @(negedge clk); c_valid = 1; c_word = mkcmd(3, 10'h045, 16'h0002);
    @(negedge clk); c_valid = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        if (c_rdy) seen++;
        @(negedge clk);
      end
      chk("R6 no-op gives no ready", seen, 0);
    end
    fab_op(0, 7'h45, 0, q, lat);
    chk("R6 no-op leaves register", q, 16'hC0DE);
  endtask

  task automatic t_contention();
    logic [15:0] qf, qc; int lf, lc;
    fork
      fab_op(1, 7'h50, 16'hAAAA, qf, lf);
      cmd_op(mkcmd(1, 10'h050, 0), qc, lc);
    join
    chk("R7 fabric served first", lf, 3);
    chk("R7 command served next", lc, 5);
    chk("R5 command read sees fabric write", qc, 16'hAAAA);
    fork
      fab_op(0, 7'h50, 0, qf, lf);
      cmd_op(mkcmd(2, 10'h050, 16'h5A5A), qc, lc);
    join
    chk("R7 fabric read before command write", qf, 16'hAAAA);
    chk("R7 command write waits", lc, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fabric_rw();
    t_status();
    t_command();
    t_contention();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule